// File: doc/BRIEF.md
# Matrix Keypad Row Scanner

This block scans a rectangular key matrix, 4 rows by 4 columns by default. It pulls one row line low at a time and leaves every other row high. While that row is low, it reads the active-low column lines. A closed key shorts its row to its column, so the column reads 0 only while the key's row is being driven.

Each row is held for a settle time before its columns are sampled. The rows are visited in ascending order, and the sequence wraps round without a pause. At the end of each full pass over the rows, the block forms a verdict: which key was seen, or that no key was seen.

A key is reported only after it has been seen on a set number of consecutive passes. It is then reported once, by a one-cycle strobe with a key index. The index holds that key until a pass sees no key at all. Key numbering is row-major, so the row being driven selects a group of COLS consecutive indices.

Top module: `kps_keypad_scanner`

## Requirements
- R1: Exactly one bit of `row_n` is 0 in every cycle, and all other bits are 1.
- R2: Each row stays driven for exactly SETTLE_CYC consecutive cycles. The columns are sampled in the last of those cycles.
- R3: Rows are driven in ascending order, from 0 to ROWS-1, and then back to 0. The low bit of `row_n` moves from bit r to bit r+1 (mod ROWS).
- R4: Bit c of `col_n` reading 0 while row r is driven means that key r*COLS+c is pressed. `key_idx` reports that 0-based number, so with 4 columns row 0 holds keys 0 to 3 and row 1 holds keys 4 to 7.
- R5: If several keys are seen in one pass, the key in the lowest-numbered row wins. Within that row, the lowest-numbered column wins.
- R6: `key_valid` pulses for exactly one cycle after the same key has won DEBOUNCE_SCANS consecutive passes. It does not pulse again while that key stays pressed.
- R7: A key that wins fewer than DEBOUNCE_SCANS consecutive passes produces no `key_valid` pulse.
- R8: A pass in which every column reads 1 for every row clears `key_idx` to 0 and re-arms the block. A later press of the same key is then reported again.
- R9: While `rst_n` is low, `row_n` drives row 0 low, `key_valid` is 0 and `key_idx` is 0.
- R10: If the winning key changes to a different key with no all-clear pass in between, the new key is counted from one. It is reported after DEBOUNCE_SCANS consecutive passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_n | output | ROWS | Row drive, active low, one row at a time |
| col_n | input | COLS | Column readback, 0 = key closed on the driven row |
| key_valid | output | 1 | One-cycle strobe for a debounced new key |
| key_idx | output | $clog2(ROWS*COLS) | Index of the reported key, 0 after release |

## Verification
The last row's column sample and the end-of-pass debounce decision are made on the same clock edge. A key on the final row must therefore be merged into the pass verdict in the very cycle it is sampled, not one pass later. The vector table provokes this case with a key on the final row, and with a pair of keys on the last two rows where the earlier row must still win. Each vector is judged on the reported index and on a latency window. The window runs from DEBOUNCE_SCANS-1 to DEBOUNCE_SCANS+1 pass lengths after the press. A merge that lost or delayed the final-row sample would report the wrong key, or report it outside that window.

// File: rtl/kps_pkg.sv
package kps_pkg;
   // Debounce tracker state
   typedef enum logic [1:0] {
      DB_IDLE  = 2'd0,   // no candidate key
      DB_COUNT = 2'd1,   // candidate seen on fewer passes than required
      DB_HELD  = 2'd2    // candidate reported, waiting for release
   } db_state_t;
endpackage

// File: rtl/kps_row_seq.sv
module kps_row_seq #(
   parameter int ROWS       = 4,
   parameter int SETTLE_CYC = 8,
   localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [RW-1:0] row_sel,
   output logic          sample,
   output logic          last_row
);
   logic [SW-1:0] settle_q;

   assign sample   = (settle_q == SW'(SETTLE_CYC - 1));
   assign last_row = sample && (row_sel == RW'(ROWS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         settle_q <= '0;
         row_sel  <= '0;
      end else if (sample) begin
         settle_q <= '0;
         row_sel  <= last_row ? '0 : row_sel + RW'(1);
      end else begin
         settle_q <= settle_q + SW'(1);
      end
   end
endmodule

// File: rtl/kps_col_prio.sv
module kps_col_prio #(
   parameter int COLS = 4,
   localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
   input  logic [COLS-1:0] col_n,
   output logic            hit,
   output logic [CW-1:0]   col
);
   // Walk from the top column down so the lowest active column is kept
   always_comb begin
      hit = 1'b0;
      col = '0;
      for (int c = COLS - 1; c >= 0; c--) begin
         if (!col_n[c]) begin
            hit = 1'b1;
            col = CW'(c);
         end
      end
   end
endmodule

// File: rtl/kps_debounce.sv
module kps_debounce
   import kps_pkg::*;
#(
   parameter int KW             = 4,
   parameter int DEBOUNCE_SCANS = 4,
   localparam int DW = $clog2(DEBOUNCE_SCANS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pass_done,
   input  logic          pass_hit,
   input  logic [KW-1:0] pass_code,
   output logic          key_valid,
   output logic [KW-1:0] key_idx
);
   db_state_t     state_q;
   logic [KW-1:0] cand_q;
   logic [DW-1:0] cnt_q;
   logic [DW-1:0] cnt_inc;

   assign cnt_inc = cnt_q + DW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= DB_IDLE;
         cand_q    <= '0;
         cnt_q     <= '0;
         key_valid <= 1'b0;
         key_idx   <= '0;
      end else begin
         key_valid <= 1'b0;
         if (pass_done) begin
            if (!pass_hit) begin
               // all-clear pass: release and re-arm
               state_q <= DB_IDLE;
               cand_q  <= '0;
               cnt_q   <= '0;
               key_idx <= '0;
            end else if (state_q == DB_IDLE || pass_code != cand_q) begin
               cand_q <= pass_code;
               cnt_q  <= DW'(1);
               if (DEBOUNCE_SCANS == 1) begin
                  state_q   <= DB_HELD;
                  key_valid <= 1'b1;
                  key_idx   <= pass_code;
               end else begin
                  state_q <= DB_COUNT;
               end
            end else if (state_q == DB_COUNT) begin
               cnt_q <= cnt_inc;
               if (cnt_inc == DW'(DEBOUNCE_SCANS)) begin
                  state_q   <= DB_HELD;
                  key_valid <= 1'b1;
                  key_idx   <= cand_q;
               end
            end
         end
      end
   end
endmodule

// File: rtl/kps_keypad_scanner.sv
module kps_keypad_scanner #(
   parameter int ROWS           = 4,
   parameter int COLS           = 4,
   parameter int SETTLE_CYC     = 8,
   parameter int DEBOUNCE_SCANS = 4,
   localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int KW = $clog2(ROWS * COLS)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [ROWS-1:0] row_n,
   input  logic [COLS-1:0] col_n,
   output logic            key_valid,
   output logic [KW-1:0]   key_idx
);
   // Elaboration-time parameter checks
   if (ROWS < 2)           begin : g_bad_rows   $error("ROWS must be at least 2");           end
   if (COLS < 2)           begin : g_bad_cols   $error("COLS must be at least 2");           end
   if (SETTLE_CYC < 1)     begin : g_bad_settle $error("SETTLE_CYC must be at least 1");     end
   if (DEBOUNCE_SCANS < 1) begin : g_bad_deb    $error("DEBOUNCE_SCANS must be at least 1"); end

   logic [RW-1:0] row_sel;
   logic          sample;
   logic          last_row;
   logic          cur_hit;
   logic [CW-1:0] cur_col;
   logic [KW-1:0] cur_code;
   logic          acc_hit_q;
   logic [KW-1:0] acc_code_q;
   logic          mrg_hit;
   logic [KW-1:0] mrg_code;

   kps_row_seq #(.ROWS(ROWS), .SETTLE_CYC(SETTLE_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .row_sel  (row_sel),
      .sample   (sample),
      .last_row (last_row)
   );

   // One-cold row drive
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_n[r] = (row_sel != RW'(r));
   end

   kps_col_prio #(.COLS(COLS)) u_prio (
      .col_n (col_n),
      .hit   (cur_hit),
      .col   (cur_col)
   );

   assign cur_code = KW'(row_sel) * KW'(COLS) + KW'(cur_col);

   // Earlier row in the pass keeps priority over later rows
   assign mrg_hit  = acc_hit_q | cur_hit;
   assign mrg_code = acc_hit_q ? acc_code_q : cur_code;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_hit_q  <= 1'b0;
         acc_code_q <= '0;
      end else if (sample) begin
         if (last_row) begin
            acc_hit_q  <= 1'b0;
            acc_code_q <= '0;
         end else begin
            acc_hit_q  <= mrg_hit;
            acc_code_q <= mrg_code;
         end
      end
   end

   kps_debounce #(.KW(KW), .DEBOUNCE_SCANS(DEBOUNCE_SCANS)) u_deb (
      .clk       (clk),
      .rst_n     (rst_n),
      .pass_done (last_row),
      .pass_hit  (mrg_hit),
      .pass_code (mrg_code),
      .key_valid (key_valid),
      .key_idx   (key_idx)
   );
endmodule

// File: rtl/kps_keypad_scanner_chk.sv
module kps_keypad_scanner_chk #(
   parameter int ROWS       = 4,
   parameter int COLS       = 4,
   parameter int SETTLE_CYC = 8,
   parameter int KW         = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [ROWS-1:0] row_n,
   input logic [COLS-1:0] col_n,
   input logic            key_valid,
   input logic [KW-1:0]   key_idx
);
   logic [ROWS-1:0] prev_row;
   int unsigned     hold_cnt;

   // hold_cnt counts the edges seen with the current row, including the edge where it changed
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_row <= row_n;
         hold_cnt <= 0;
      end else begin
         prev_row <= row_n;
         if (row_n != prev_row)               hold_cnt <= 1;
         else if (hold_cnt <= SETTLE_CYC)     hold_cnt <= hold_cnt + 1;
      end
   end

   p_one_row_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(row_n) == ROWS - 1);

   p_settle_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (row_n != prev_row) |-> (hold_cnt == SETTLE_CYC));

   p_row_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (row_n != prev_row) |-> (row_n == {prev_row[ROWS-2:0], prev_row[ROWS-1]}));

   p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |=> !key_valid);

   p_idx_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (key_idx != $past(key_idx)) |-> (key_valid || key_idx == '0));
endmodule

bind kps_keypad_scanner kps_keypad_scanner_chk #(
   .ROWS(ROWS), .COLS(COLS), .SETTLE_CYC(SETTLE_CYC), .KW(KW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .row_n     (row_n),
   .col_n     (col_n),
   .key_valid (key_valid),
   .key_idx   (key_idx)
);

// File: tb/kps_keypad_scanner_tb.sv
`timescale 1ns/1ps
module kps_keypad_scanner_tb;
   localparam int ROWS = 4;
   localparam int COLS = 4;
   localparam int SET  = 3;
   localparam int DEB  = 3;
   localparam int P    = ROWS * SET;   // cycles per pass
   localparam int NV   = 7;

   // pressed-key mask (bit k = key k) and the expected winner
   localparam logic [15:0] VEC_MASK [NV] = '{
      16'h0001, 16'h0020, 16'h8000, 16'h0400,
      16'h00C0, 16'h1200, 16'h000C };
   localparam logic [3:0]  VEC_IDX  [NV] = '{
      4'd0, 4'd5, 4'd15, 4'd10, 4'd6, 4'd9, 4'd2 };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [ROWS-1:0] row_n;
   logic [COLS-1:0] col_n;
   logic            key_valid;
   logic [3:0]      key_idx;
   logic [15:0]     pressed = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   // behavioural matrix: a pressed key shorts its row to its column
   always_comb begin
      for (int c = 0; c < COLS; c++) begin
         col_n[c] = 1'b1;
         for (int r = 0; r < ROWS; r++)
            if (!row_n[r] && pressed[r*COLS + c]) col_n[c] = 1'b0;
      end
   end

   kps_keypad_scanner #(
      .ROWS(ROWS), .COLS(COLS), .SETTLE_CYC(SET), .DEBOUNCE_SCANS(DEB)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
      .key_valid(key_valid), .key_idx(key_idx)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // wait for a strobe; lat = cycles from call, -1 if none
   task automatic wait_valid(output int lat, output int idx);
      lat = -1;
      idx = -1;
      for (int i = 1; i <= (DEB + 2) * P; i++) begin
         @(negedge clk);
         if (key_valid && lat < 0) begin
            lat = i;
            idx = int'(key_idx);
         end
         if (lat >= 0) break;
      end
   endtask

   task automatic count_valid(input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (key_valid) cnt++;
      end
   endtask

   initial begin
      int lat, idx, cnt;
      int low_cnt [ROWS];
      int bad_order;
      logic [ROWS-1:0] prv;

      // R9: reset state
      repeat (3) @(negedge clk);
      chk(row_n == 4'b1110, "R9 row_n in reset", int'(row_n), 14);
      chk(key_valid == 1'b0, "R9 key_valid in reset", int'(key_valid), 0);
      chk(key_idx == 4'd0, "R9 key_idx in reset", int'(key_idx), 0);
      rst_n = 1'b1;

      // R1 R2 R3: row walk over two passes
      for (int r = 0; r < ROWS; r++) low_cnt[r] = 0;
      bad_order = 0;
      prv = row_n;
      for (int i = 0; i < 2 * P; i++) begin
         @(negedge clk);
         if ($countones(row_n) != ROWS - 1) bad_order += 100;
         for (int r = 0; r < ROWS; r++) if (!row_n[r]) low_cnt[r]++;
         if (row_n != prv && row_n != {prv[ROWS-2:0], prv[ROWS-1]}) bad_order++;
         prv = row_n;
      end
      chk(bad_order < 100, "R1 one row low", bad_order, 0);
      chk(bad_order % 100 == 0, "R3 ascending row order", bad_order % 100, 0);
      for (int r = 0; r < ROWS; r++)
         chk(low_cnt[r] == 2 * SET, "R2 row held SETTLE cycles", low_cnt[r], 2 * SET);

      // R4 R5 R6 R8: vector table
      for (int v = 0; v < NV; v++) begin
         pressed = VEC_MASK[v];
         wait_valid(lat, idx);
         chk(idx == int'(VEC_IDX[v]), "R4/R5 key index", idx, int'(VEC_IDX[v]));
         chk(lat >= (DEB - 1) * P && lat <= (DEB + 1) * P, "R6 debounce latency", lat, DEB * P);
         count_valid(4 * P, cnt);
         chk(cnt == 0, "R6 single report per press", cnt, 0);
         chk(key_idx == VEC_IDX[v], "R8 index held while pressed", int'(key_idx), int'(VEC_IDX[v]));
         pressed = '0;
         count_valid(2 * P + 1, cnt);
         chk(key_idx == 4'd0 && cnt == 0, "R8 release clears index", int'(key_idx), 0);
      end

      // R7: press too short to be debounced
      pressed = 16'h0008;
      repeat ((DEB - 2) * P) @(negedge clk);
      pressed = '0;
      count_valid(4 * P, cnt);
      chk(cnt == 0, "R7 short press ignored", cnt, 0);
      chk(key_idx == 4'd0, "R7 index unchanged", int'(key_idx), 0);

      // R8: same key reported again after release
      pressed = 16'h0800;
      wait_valid(lat, idx);
      chk(idx == 11, "R8 first press", idx, 11);
      pressed = '0;
      repeat (2 * P + 1) @(negedge clk);
      pressed = 16'h0800;
      wait_valid(lat, idx);
      chk(idx == 11, "R8 re-press reported", idx, 11);

      // R10: key change with no release in between
      pressed = 16'h0100;
      wait_valid(lat, idx);
      chk(idx == 8, "R10 changed key reported", idx, 8);
      chk(lat >= (DEB - 1) * P && lat <= (DEB + 1) * P, "R10 changed key latency", lat, DEB * P);
      pressed = '0;
      repeat (2 * P + 1) @(negedge clk);
      chk(key_idx == 4'd0, "R8 final release", int'(key_idx), 0);

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule